// File: doc/BRIEF.md
# Burst-Mode Memory Channel Transmitter

This block is a transmit channel that streams a range of bytes from on-chip memory to an external host. Software first programs a mode register for transmit direction and burst operation. It then loads a first and a last address, and writes the start command. From then on the channel fetches one byte at a time into a single-byte transmit buffer, using a request/acknowledge memory port.

After the first byte is in the buffer, the channel raises its DMA request line and holds it for the whole burst. The host takes bytes with an active-low read strobe. Each rising edge of that strobe, seen after a two-stage synchronizer, starts the fetch of the next byte. Once the byte at the last address is in the buffer, the request line falls one clock later. The host's next strobe rising edge closes the operation: the start bit clears itself and a sticky end-of-operation interrupt is raised.

The byte output shows the buffer only during a qualified host read. At all other times it is held at zero.

Top module: `mc_burst_tx`

## Requirements
- R1: After reset, `dma_req`, `op_end_irq` and `mem_req` are 0, and `ext_dout` is 0.
- R2: A write with `cfg_sel`=1 and `cfg_wdata[0]`=1 starts an operation only if the mode register (`cfg_sel`=0) holds direction `cfg_wdata[1:0]`=2'b10 and burst bit `cfg_wdata[2]`=1. Any other mode leaves `mem_req` and `dma_req` at 0.
- R3: In the clock after an accepted start, `mem_req` is 1 and `mem_addr` equals the start address (`cfg_sel`=2). `mem_req` and `mem_addr` hold until `mem_ack`. The `mem_rdata` sampled with `mem_ack` becomes the buffered byte.
- R4: The address advances by one with every byte loaded. The bytes reach the host in address order, from the start address to the end address (`cfg_sel`=3) inclusive.
- R5: `dma_req` rises in the clock after the first byte is loaded. It stays 1 through the burst until the end-address byte has been loaded.
- R6: Between bytes, no memory read is issued until a rising edge of the synchronized `ext_rd_n` is seen. Each such edge causes exactly one fetch.
- R7: One clock after the end-address byte is loaded, `dma_req` falls. No further memory read is issued.
- R8: The first strobe rising edge after the end-address fetch sets `op_end_irq` and ends the operation. Later strobes cause no fetch.
- R9: `op_end_irq` stays 1 until a write with `cfg_sel`=1 and `cfg_wdata[1]`=1. A write with that bit at 0 leaves it set.
- R10: `ext_dout` equals the buffered byte only while `ext_cs`=1, `ext_dack_n`=0 and `ext_rd_n`=0. Otherwise it is 0.
- R11: A burst whose start and end addresses are equal moves exactly one byte. `dma_req` is high for one clock only, and the burst then completes on the next strobe rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 control, 2 start address, 3 end address |
| cfg_wdata | input | ADDR_W | Configuration write data |
| mem_req | output | 1 | Internal memory read request |
| mem_addr | output | ADDR_W | Internal memory read address |
| mem_ack | input | 1 | Internal memory acknowledge, data valid |
| mem_rdata | input | DATA_W | Internal memory read data |
| ext_cs | input | 1 | Host chip select, active high |
| ext_dack_n | input | 1 | Host DMA acknowledge, active low |
| ext_rd_n | input | 1 | Host read strobe, active low |
| ext_dout | output | DATA_W | Byte to host, gated by a qualified read |
| dma_req | output | 1 | DMA request to host |
| op_end_irq | output | 1 | Sticky end-of-operation interrupt |

## Verification
The bench checks the boundaries of the request line. Before every host read it compares `dma_req` with whether more than one byte is still owed, so a design that drops the request too early or keeps it through the final byte is caught. A one-byte burst exercises the case where the start and the end coincide, where a design that compares the address after incrementing would run past the end. Memory latency varies between fetches, so a design that samples read data before the acknowledge delivers wrong bytes to the scoreboard. Strobe edges after completion, and gated reads with chip select or acknowledge inactive, expose designs that restart fetching or leak the buffer onto the output.

// File: rtl/mctx_pkg.sv
package mctx_pkg;

    typedef enum logic [1:0] {
        F_IDLE  = 2'd0,
        F_FETCH = 2'd1,
        F_SERVE = 2'd2,
        F_TAIL  = 2'd3
    } fetch_st_e;

    typedef enum logic [1:0] {
        SEL_MODE  = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_START = 2'd2,
        SEL_END   = 2'd3
    } cfg_sel_e;

    localparam logic [1:0] DIR_TRANSMIT  = 2'b10;
    localparam int         MODE_BURST_BIT = 2;
    localparam int         CTRL_EN_BIT    = 0;
    localparam int         CTRL_CLR_BIT   = 1;

endpackage

// File: rtl/mctx_rd_edge.sv
module mctx_rd_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_n,
    output logic rd_rise
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } edge_t;

    edge_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[STAGES-2:0], rd_n};
        d.last = q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign rd_rise = q.sync[STAGES-1] & ~q.last;

endmodule

// File: rtl/mctx_fetch.sv
module mctx_fetch
    import mctx_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] addr_ld_val,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic              rd_rise,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] txbuf,
    output logic              dreq,
    output logic              done
);

    typedef struct packed {
        fetch_st_e         st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] buf_v;
        logic              dreq;
    } fetch_t;

    fetch_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        case (q.st)
            F_IDLE: begin
                if (addr_ld) d.addr = addr_ld_val;
                if (start)   d.st   = F_FETCH;
            end
            F_FETCH: begin
                if (mem_ack) begin
                    d.buf_v = mem_rdata;
                    d.addr  = q.addr + 1'b1;
                    d.dreq  = 1'b1;
                    d.st    = (q.addr == end_addr) ? F_TAIL : F_SERVE;
                end
            end
            F_SERVE: begin
                if (rd_rise) d.st = F_FETCH;
            end
            F_TAIL: begin
                d.dreq = 1'b0;
                if (rd_rise) begin
                    d.st = F_IDLE;
                    done = 1'b1;
                end
            end
            default: d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: F_IDLE, addr: '0, buf_v: '0, dreq: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign mem_req  = (q.st == F_FETCH);
    assign mem_addr = q.addr;
    assign txbuf    = q.buf_v;
    assign dreq     = q.dreq;

    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    a_r5_req_in_serve: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == F_SERVE) |-> dreq);

endmodule

// File: rtl/mc_burst_tx.sv
module mc_burst_tx
    import mctx_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              ext_cs,
    input  logic              ext_dack_n,
    input  logic              ext_rd_n,
    output logic [DATA_W-1:0] ext_dout,
    output logic              dma_req,
    output logic              op_end_irq
);

    typedef struct packed {
        logic [1:0]        dir;
        logic              burst;
        logic [ADDR_W-1:0] end_addr;
        logic              en;
        logic              irq;
    } ctl_t;

    ctl_t q, d;

    logic              rd_rise;
    logic              done;
    logic              start;
    logic              ctrl_wr;
    logic              mode_ok;
    logic              addr_ld;
    logic [DATA_W-1:0] txbuf;

    mctx_rd_edge #(.STAGES(SYNC_STAGES)) u_rd_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_n    (ext_rd_n),
        .rd_rise (rd_rise)
    );

    always_comb begin
        d       = q;
        ctrl_wr = cfg_we && (cfg_sel == SEL_CTRL);
        addr_ld = cfg_we && (cfg_sel == SEL_START);
        mode_ok = (q.dir == DIR_TRANSMIT) && q.burst;
        start   = ctrl_wr && cfg_wdata[CTRL_EN_BIT] && mode_ok && !q.en;

        if (cfg_we && (cfg_sel == SEL_MODE)) begin
            d.dir   = cfg_wdata[1:0];
            d.burst = cfg_wdata[MODE_BURST_BIT];
        end
        if (cfg_we && (cfg_sel == SEL_END)) d.end_addr = cfg_wdata;

        if (start)     d.en = 1'b1;
        else if (done) d.en = 1'b0;

        if (done)                                 d.irq = 1'b1;
        else if (ctrl_wr && cfg_wdata[CTRL_CLR_BIT]) d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    mctx_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .addr_ld     (addr_ld),
        .addr_ld_val (cfg_wdata),
        .end_addr    (q.end_addr),
        .rd_rise     (rd_rise),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .txbuf       (txbuf),
        .dreq        (dma_req),
        .done        (done)
    );

    assign ext_dout   = (ext_cs && !ext_dack_n && !ext_rd_n) ? txbuf : '0;
    assign op_end_irq = q.irq;

    a_r8_irq_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_end_irq) |-> $past(rd_rise));

    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (op_end_irq && !(cfg_we && cfg_sel == SEL_CTRL && cfg_wdata[CTRL_CLR_BIT]))
        |=> op_end_irq);

    a_r2_no_fetch_idle_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.en) |-> !mem_req);

endmodule

// File: tb/mc_burst_tx_tb.sv
`timescale 1ns/100ps
module mc_burst_tx_tb;

    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          ext_cs = 1'b1;
    logic          ext_dack_n = 1'b0;
    logic          ext_rd_n = 1'b1;
    logic [DW-1:0] ext_dout;
    logic          dma_req;
    logic          op_end_irq;

    int n_chk  = 0;
    int n_fail = 0;
    logic [DW-1:0] exp_q[$];
    logic [AW-1:0] exp_addr = '0;
    bit            mon_on = 1'b1;
    logic          rd_prev = 1'b1;
    int            lat = 0;

    always #2.5 clk = ~clk;

    mc_burst_tx u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .ext_cs(ext_cs),
        .ext_dack_n(ext_dack_n), .ext_rd_n(ext_rd_n), .ext_dout(ext_dout),
        .dma_req(dma_req), .op_end_irq(op_end_irq)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // memory model with varying latency; checks the address order (R4)
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && !mem_ack) begin
                repeat (lat) @(negedge clk);
                chk(mem_addr == exp_addr, "R4 fetch address", 32'(mem_addr), 32'(exp_addr));
                exp_addr  = exp_addr + 1'b1;
                mem_rdata = pat(mem_addr);
                mem_ack   = 1'b1;
                @(negedge clk);
                mem_ack   = 1'b0;
                lat       = (lat + 1) % 3;
            end
        end
    end

    // scoreboard monitor: one expected byte per qualified read (R3, R4)
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && !ext_rd_n && rd_prev && ext_cs && !ext_dack_n) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected read", 32'(ext_dout), 32'hFFFF_FFFF);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(ext_dout == e, "R3 read data", 32'(ext_dout), 32'(e));
                end
            end
            rd_prev = ext_rd_n;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R8 watchdog", 32'h0, 32'h1);
        summary();
        $finish;
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk);
        ext_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        ext_rd_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic run_burst(input logic [AW-1:0] first, input logic [AW-1:0] last);
        int n;
        n = int'(AW'(last - first)) + 1;
        exp_addr = first;
        for (int k = 0; k < n; k++) exp_q.push_back(pat(AW'(first + AW'(k))));
        cfg_write(2'd2, first);
        cfg_write(2'd3, last);
        cfg_write(2'd1, 16'h0001);
        chk(mem_req && mem_addr == first, "R3 first request", 32'(mem_addr), 32'(first));
        repeat (15) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            chk(dma_req == (i < n - 1), "R5 R7 dma_req level", 32'(dma_req), 32'(i < n - 1));
            chk(!mem_req, "R6 no fetch before strobe", 32'(mem_req), 32'h0);
            if (i == n - 1) chk(!op_end_irq, "R8 irq before last strobe", 32'(op_end_irq), 32'h0);
            host_read();
        end
        chk(op_end_irq, "R8 irq after last strobe", 32'(op_end_irq), 32'h1);
        chk(exp_q.size() == 0, "R4 all bytes delivered", 32'(exp_q.size()), 32'h0);
        chk(!mem_req && !dma_req, "R7 quiet after end", 32'({mem_req, dma_req}), 32'h0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(!dma_req && !op_end_irq && !mem_req, "R1 reset outputs",
            32'({dma_req, op_end_irq, mem_req}), 32'h0);
        chk(ext_dout == '0, "R1 reset dout", 32'(ext_dout), 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2: wrong direction, then burst bit cleared
        cfg_write(2'd2, 16'h0040);
        cfg_write(2'd0, 16'h0005);
        cfg_write(2'd1, 16'h0001);
        repeat (10) @(negedge clk);
        chk(!mem_req && !dma_req, "R2 wrong direction ignored", 32'({mem_req, dma_req}), 32'h0);
        cfg_write(2'd0, 16'h0002);
        cfg_write(2'd1, 16'h0001);
        repeat (10) @(negedge clk);
        chk(!mem_req && !dma_req, "R2 no burst ignored", 32'({mem_req, dma_req}), 32'h0);

        cfg_write(2'd0, 16'h0006);
        run_burst(16'h0100, 16'h0103);

        // R10: output gating, strobes after completion (R8)
        mon_on = 1'b0;
        @(negedge clk); ext_cs = 1'b0; ext_rd_n = 1'b0;
        @(negedge clk);
        chk(ext_dout == '0, "R10 cs low gated", 32'(ext_dout), 32'h0);
        ext_cs = 1'b1; ext_dack_n = 1'b1;
        @(negedge clk);
        chk(ext_dout == '0, "R10 dack high gated", 32'(ext_dout), 32'h0);
        ext_dack_n = 1'b0;
        @(negedge clk);
        chk(ext_dout == pat(16'h0103), "R10 qualified read", 32'(ext_dout), 32'(pat(16'h0103)));
        ext_rd_n = 1'b1;
        @(negedge clk);
        chk(ext_dout == '0, "R10 read high gated", 32'(ext_dout), 32'h0);
        repeat (10) @(negedge clk);
        chk(!mem_req && op_end_irq, "R8 no fetch after end", 32'({mem_req, op_end_irq}), 32'h1);
        rd_prev = 1'b1;
        mon_on = 1'b1;

        // R9: sticky interrupt
        cfg_write(2'd1, 16'h0000);
        chk(op_end_irq, "R9 irq kept on zero write", 32'(op_end_irq), 32'h1);
        cfg_write(2'd1, 16'h0002);
        @(negedge clk);
        chk(!op_end_irq, "R9 irq cleared", 32'(op_end_irq), 32'h0);

        // R11: single-byte burst
        run_burst(16'h20FE, 16'h20FE);
        cfg_write(2'd1, 16'h0002);

        run_burst(16'h3A10, 16'h3A17);

        summary();
        $finish;
    end

endmodule